// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture

This block is a memory-mapped timer peripheral. A prescale counter divides the peripheral clock, and every time it completes a period the timer counter advances by one. Four compare channels watch the timer counter. When a channel's value equals the counter at a count step, the channel can raise an interrupt flag, restart the counter from zero, and/or halt counting. Each action is chosen per channel. Two capture inputs are synchronised to the clock. On a chosen edge of a capture input, the current timer count is copied into that channel's capture register, and this can also raise a flag.

Software reaches the block through a single-cycle write strobe with a byte address and write data. Read data is combinational from the address. Both counters can be read and overwritten. A pending-flag register collects all match and capture flags. Writing ones to it clears the matching flags, and the interrupt output is high while any flag is pending.

Top module: `ptmr_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With the enable bit (control bit 0) set and prescale value p, the prescale counter steps 0,1,..,p. On the clock after it equals p it returns to 0 and the timer counter increments, so the timer advances once per p+1 clocks.
- R3: With control bit 0 clear, neither counter changes.
- R4: While control bit 1 is set, both counters are held at zero, even when bit 0 is also set.
- R5: A count step taken while the timer equals compare value n, with control bit 3n of the match register set, sets pending bit n and raises `irq`.
- R6: When bit 3n+1 is set, that count step loads the timer with 0 instead of incrementing it, giving a period of value+1 steps.
- R7: When bit 3n+2 is set, that count step leaves the timer at the compare value, clears the prescale counter and clears control bit 0. If restart is also selected, the timer goes to 0.
- R8: A write to the pending register clears every bit written as 1 and leaves bits written as 0 alone. `irq` is the OR of all pending bits. Match flags are bits 0-3 and capture flags are bits 4-5.
- R9: Capture configuration bit 3n selects the rising edge of capture input n. On that edge, after a two-flop synchroniser, the capture register loads the current timer count.
- R10: Configuration bit 3n+1 selects the falling edge. An edge that is not selected leaves the capture register unchanged.
- R11: Configuration bit 3n+2 makes a capture on channel n set pending bit 4+n. Without it, no flag is set.
- R12: The byte offsets are: pending flags 0x00, control 0x04, timer 0x08, prescale value 0x0C, prescale counter 0x10, match control 0x14, compare values 0x18-0x24, capture configuration 0x28, capture registers 0x2C and 0x30. A bus write to the timer or to the prescale counter takes precedence over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cap_in | input | 2 | Asynchronous capture inputs |
| irq | output | 1 | High while any pending flag is set |

## Verification
The counting path is tried with a table of prescale values, compare values and run lengths. The table covers a free-running counter, a restart-on-match counter and a stop-on-match counter, with runs that end before, at and after the match step. Wrong period arithmetic, wrong wrap points and wrong stop values therefore show up as different final counts and prescale residues. Capture is tried with rising and falling edges, both selected and unselected, and at different frozen timer values. This tells edge selection apart from any-edge capture, and flag-enabled capture from flag-free capture. Pending-flag writes that use zeros and ones tell a write-one-to-clear register apart from a plain overwrite.

// File: rtl/ptmr_pkg.sv
// Package ptmr_pkg
// Holds the register byte offsets and the per-channel action encodings
// shared by the timer blocks and the checker.
// Assumes a byte-addressed register space with 32-bit aligned registers.
package ptmr_pkg;

    localparam int OFF_IR   = 'h00;
    localparam int OFF_CTRL = 'h04;
    localparam int OFF_TC   = 'h08;
    localparam int OFF_PR   = 'h0C;
    localparam int OFF_PC   = 'h10;
    localparam int OFF_MCR  = 'h14;
    localparam int OFF_MR0  = 'h18;

    // Per match channel action bits (three bits per channel)
    typedef struct packed {
        logic halt;
        logic restart;
        logic flag;
    } match_act_t;

    // Per capture channel selection bits (three bits per channel)
    typedef struct packed {
        logic flag;
        logic fall;
        logic rise;
    } cap_cfg_t;

endpackage

// File: rtl/ptmr_counter.sv
// Module ptmr_counter
// Prescale counter and timer counter. The prescale counter runs from 0 up
// to the prescale value; the clock after equality is a count step that
// clears it and advances the timer. Hold-in-reset wins over everything,
// bus writes win over counting, and match restart/halt requests
// (already qualified with the step) alter what the step does to the timer.
// Assumes all inputs are synchronous to clk.
module ptmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         hold,
    input  logic [W-1:0] pr,
    input  logic         tc_wr,
    input  logic         pc_wr,
    input  logic [W-1:0] wdata,
    input  logic         m_restart,
    input  logic         m_halt,
    output logic [W-1:0] tc,
    output logic [W-1:0] pc,
    output logic         tick
);

    // Count step: enabled, not held, prescale period complete
    assign tick = en && !hold && (pc == pr);

    // Timer counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= '0;
        end else if (hold) begin
            tc <= '0;
        end else if (tc_wr) begin
            tc <= wdata;
        end else if (tick) begin
            if (m_restart) begin
                tc <= '0;
            end else if (!m_halt) begin
                tc <= tc + 1'b1;
            end
        end
    end

    // Prescale counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (hold) begin
            pc <= '0;
        end else if (pc_wr) begin
            pc <= wdata;
        end else if (tick) begin
            pc <= '0;
        end else if (en) begin
            pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/ptmr_match.sv
// Module ptmr_match
// Compares the timer against each compare value on a count step and turns
// hits into per-channel flags plus merged restart and halt requests.
// Assumes the action field holds three bits per channel: flag, restart,
// halt from low to high.
module ptmr_match
    import ptmr_pkg::*;
#(
    parameter int W = 32,
    parameter int N = 4
) (
    input  logic [W-1:0]         tc,
    input  logic                 tick,
    input  logic [N-1:0][W-1:0]  mr,
    input  logic [3*N-1:0]       mcr,
    output logic [N-1:0]         hit,
    output logic [N-1:0]         flag,
    output logic                 restart_req,
    output logic                 halt_req
);

    logic [N-1:0] restart_v;
    logic [N-1:0] halt_v;

    for (genvar n = 0; n < N; n++) begin : g_ch
        match_act_t act;
        assign act = mcr[3*n +: 3];
        // Channel hit and its selected actions
        assign hit[n]       = tick && (tc == mr[n]);
        assign flag[n]      = hit[n] && act.flag;
        assign restart_v[n] = hit[n] && act.restart;
        assign halt_v[n]    = hit[n] && act.halt;
    end

    assign restart_req = |restart_v;
    assign halt_req    = |halt_v;

endmodule

// File: rtl/ptmr_capture.sv
// Module ptmr_capture
// Synchronises each capture input, detects its edges, and loads the timer
// value into the channel register on the selected edge(s).
// Assumes the inputs are low while reset is applied (a high input at the
// release of reset reads as a rising edge).
module ptmr_capture
    import ptmr_pkg::*;
#(
    parameter int W    = 32,
    parameter int N    = 2,
    parameter int SYNC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        cap_in,
    input  logic [3*N-1:0]      ccr,
    input  logic [W-1:0]        tc,
    output logic [N-1:0][W-1:0] cr,
    output logic [N-1:0]        flag
);

    for (genvar n = 0; n < N; n++) begin : g_ch
        cap_cfg_t        cfg;
        logic [SYNC-1:0] sync_q;
        logic            prev_q;
        logic            level;
        logic            evt;

        assign cfg   = ccr[3*n +: 3];
        assign level = sync_q[SYNC-1];
        assign evt   = (cfg.rise && level && !prev_q) ||
                       (cfg.fall && !level && prev_q);
        assign flag[n] = evt && cfg.flag;

        // Synchroniser chain and edge history
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC-2:0], cap_in[n]};
                prev_q <= level;
            end
        end

        // Capture register load on a selected edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cr[n] <= '0;
            end else if (evt) begin
                cr[n] <= tc;
            end
        end
    end

endmodule

// File: rtl/ptmr_top.sv
// Module ptmr_top
// Timer peripheral top: register file, write decode, pending flags and read
// mux around the counter, match and capture blocks.
// Assumes one write per strobe cycle; reads are combinational from the
// address; unmapped addresses read zero and ignore writes.
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int DW      = 32,
    parameter int ADDR_W  = 6,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 2,
    parameter int SYNC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N_CAP-1:0]  cap_in,
    output logic              irq
);

    localparam int IRW     = N_MATCH + N_CAP;
    localparam int MCR_W   = 3 * N_MATCH;
    localparam int CCR_W   = 3 * N_CAP;
    localparam int OFF_CCR = OFF_MR0 + 4 * N_MATCH;
    localparam int OFF_CR0 = OFF_CCR + 4;

    logic                      ctrl_en;
    logic                      ctrl_rst;
    logic [DW-1:0]             pr_q;
    logic [MCR_W-1:0]          mcr_q;
    logic [N_MATCH-1:0][DW-1:0] mr_q;
    logic [CCR_W-1:0]          ccr_q;
    logic [IRW-1:0]            ir_q;
    logic [IRW-1:0]            ir_set;
    logic [IRW-1:0]            ir_clr;

    logic [DW-1:0]             tc_q;
    logic [DW-1:0]             pc_q;
    logic                      tick;
    logic [N_MATCH-1:0]        match_hit;
    logic [N_MATCH-1:0]        match_flag;
    logic                      restart_req;
    logic                      stop_req;
    logic [N_CAP-1:0][DW-1:0]  cr_q;
    logic [N_CAP-1:0]          cap_flag;

    logic wr_ir, wr_ctrl, wr_tc, wr_pr, wr_pc, wr_mcr, wr_ccr;
    logic [N_MATCH-1:0] wr_mr;

    // Write decode per register
    assign wr_ir   = bus_wr && (bus_addr == ADDR_W'(OFF_IR));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_tc   = bus_wr && (bus_addr == ADDR_W'(OFF_TC));
    assign wr_pr   = bus_wr && (bus_addr == ADDR_W'(OFF_PR));
    assign wr_pc   = bus_wr && (bus_addr == ADDR_W'(OFF_PC));
    assign wr_mcr  = bus_wr && (bus_addr == ADDR_W'(OFF_MCR));
    assign wr_ccr  = bus_wr && (bus_addr == ADDR_W'(OFF_CCR));

    for (genvar i = 0; i < N_MATCH; i++) begin : g_mr
        assign wr_mr[i] = bus_wr && (bus_addr == ADDR_W'(OFF_MR0 + 4 * i));

        // Compare value register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mr_q[i] <= '0;
            end else if (wr_mr[i]) begin
                mr_q[i] <= bus_wdata;
            end
        end
    end

    // Control bits: software writes win, a halting match clears enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_rst <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_en  <= bus_wdata[0];
            ctrl_rst <= bus_wdata[1];
        end else if (stop_req) begin
            ctrl_en  <= 1'b0;
        end
    end

    // Plain configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q  <= '0;
            mcr_q <= '0;
            ccr_q <= '0;
        end else begin
            if (wr_pr)  pr_q  <= bus_wdata;
            if (wr_mcr) mcr_q <= bus_wdata[MCR_W-1:0];
            if (wr_ccr) ccr_q <= bus_wdata[CCR_W-1:0];
        end
    end

    // Pending flags: new events set, written ones clear, set wins
    assign ir_set = {cap_flag, match_flag};
    assign ir_clr = wr_ir ? bus_wdata[IRW-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else begin
            ir_q <= (ir_q & ~ir_clr) | ir_set;
        end
    end

    assign irq = |ir_q;

    ptmr_counter #(.W(DW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_en),
        .hold      (ctrl_rst),
        .pr        (pr_q),
        .tc_wr     (wr_tc),
        .pc_wr     (wr_pc),
        .wdata     (bus_wdata),
        .m_restart (restart_req),
        .m_halt    (stop_req),
        .tc        (tc_q),
        .pc        (pc_q),
        .tick      (tick)
    );

    ptmr_match #(.W(DW), .N(N_MATCH)) u_match (
        .tc          (tc_q),
        .tick        (tick),
        .mr          (mr_q),
        .mcr         (mcr_q),
        .hit         (match_hit),
        .flag        (match_flag),
        .restart_req (restart_req),
        .halt_req    (stop_req)
    );

    ptmr_capture #(.W(DW), .N(N_CAP), .SYNC(SYNC)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_in (cap_in),
        .ccr    (ccr_q),
        .tc     (tc_q),
        .cr     (cr_q),
        .flag   (cap_flag)
    );

    // Read mux by byte offset
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IR))   bus_rdata[IRW-1:0]   = ir_q;
        if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata[1:0]       = {ctrl_rst, ctrl_en};
        if (bus_addr == ADDR_W'(OFF_TC))   bus_rdata            = tc_q;
        if (bus_addr == ADDR_W'(OFF_PR))   bus_rdata            = pr_q;
        if (bus_addr == ADDR_W'(OFF_PC))   bus_rdata            = pc_q;
        if (bus_addr == ADDR_W'(OFF_MCR))  bus_rdata[MCR_W-1:0] = mcr_q;
        if (bus_addr == ADDR_W'(OFF_CCR))  bus_rdata[CCR_W-1:0] = ccr_q;
        for (int i = 0; i < N_MATCH; i++) begin
            if (bus_addr == ADDR_W'(OFF_MR0 + 4 * i)) bus_rdata = mr_q[i];
        end
        for (int i = 0; i < N_CAP; i++) begin
            if (bus_addr == ADDR_W'(OFF_CR0 + 4 * i)) bus_rdata = cr_q[i];
        end
    end

endmodule

// File: rtl/ptmr_chk.sv
// Module ptmr_chk
// Temporal checks on the timer's counters, control and pending flags,
// attached to ptmr_top by bind. Observes only; drives nothing.
module ptmr_chk
    import ptmr_pkg::*;
#(
    parameter int DW      = 32,
    parameter int ADDR_W  = 6,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DW-1:0]             bus_wdata,
    input logic                      ctrl_en,
    input logic                      ctrl_rst,
    input logic [DW-1:0]             tc,
    input logic [DW-1:0]             pc,
    input logic [DW-1:0]             pr,
    input logic [N_MATCH+N_CAP-1:0]  ir,
    input logic [N_MATCH+N_CAP-1:0]  set_vec,
    input logic [N_MATCH-1:0]        match_flag,
    input logic                      stop_req
);

    localparam int IRW = N_MATCH + N_CAP;

    logic pc_wr, tc_wr, ctrl_wr, ir_wr;
    assign pc_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_PC));
    assign tc_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_TC));
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign ir_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_IR));

    // R2: prescale counter steps by one below the prescale value
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !ctrl_rst && !pc_wr && pc != pr) |=> (pc == $past(pc) + 1'b1));

    // R2: prescale counter wraps to zero after reaching the prescale value
    assert_pc_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !ctrl_rst && !pc_wr && pc == pr) |=> (pc == '0));

    // R3: disabled counters stay put
    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !ctrl_rst && !pc_wr && !tc_wr) |=> ($stable(tc) && $stable(pc)));

    // R4: hold-in-reset forces both counters to zero
    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst |=> (tc == '0 && pc == '0));

    // R5: a flagged match sets its pending bit
    assert_match_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|match_flag) |=> ((ir[N_MATCH-1:0] & $past(match_flag)) == $past(match_flag)));

    // R7: a halting match clears the enable bit
    assert_stop_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !ctrl_wr) |=> !ctrl_en);

    // R8: ones written to the pending register clear those bits
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_wr && set_vec == '0) |=> ((ir & $past(bus_wdata[IRW-1:0])) == '0));

endmodule

bind ptmr_top ptmr_chk #(
    .DW      (DW),
    .ADDR_W  (ADDR_W),
    .N_MATCH (N_MATCH),
    .N_CAP   (N_CAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ctrl_en    (ctrl_en),
    .ctrl_rst   (ctrl_rst),
    .tc         (tc_q),
    .pc         (pc_q),
    .pr         (pr_q),
    .ir         (ir_q),
    .set_vec    (ir_set),
    .match_flag (match_flag),
    .stop_req   (stop_req)
);

// File: tb/sim_ptmr_top.sv
// Bench for ptmr_top: a vector table for the counting and match modes,
// then directed tests for reset, hold, flags, bus overrides and capture.
module sim_ptmr_top;

    localparam logic [5:0] A_IR   = 6'h00;
    localparam logic [5:0] A_CTRL = 6'h04;
    localparam logic [5:0] A_TC   = 6'h08;
    localparam logic [5:0] A_PR   = 6'h0C;
    localparam logic [5:0] A_PC   = 6'h10;
    localparam logic [5:0] A_MCR  = 6'h14;
    localparam logic [5:0] A_MR0  = 6'h18;
    localparam logic [5:0] A_MR1  = 6'h1C;
    localparam logic [5:0] A_MR2  = 6'h20;
    localparam logic [5:0] A_CCR  = 6'h28;
    localparam logic [5:0] A_CR0  = 6'h2C;
    localparam logic [5:0] A_CR1  = 6'h30;

    // mode: 0 free run, 1 flag+restart on match 0, 2 flag+halt on match 0
    typedef struct packed {
        logic [31:0] pr;
        logic [31:0] mr;
        logic [1:0]  mode;
        logic [31:0] k;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'd0, 32'd100, 2'd0, 32'd7},
        '{32'd3, 32'd100, 2'd0, 32'd10},
        '{32'd2, 32'd4,   2'd1, 32'd20},
        '{32'd0, 32'd3,   2'd1, 32'd9},
        '{32'd1, 32'd5,   2'd2, 32'd30},
        '{32'd4, 32'd9,   2'd2, 32'd23}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ptmr_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Enable, let k count edges pass, then disable (k >= 1)
    task automatic run_edges(input int k);
        wr(A_CTRL, 32'h1);
        repeat (k - 1) @(negedge clk);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic clear_counters;
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_IR, 32'hFF);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r, r2;
        int ticks, e_tc, e_pc, e_ir;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register zero after reset
        for (int a = 0; a <= 'h30; a += 4) begin
            rd(6'(a), r);
            chk("R1 reset value", r, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // Vector table: R2 / R6 / R7 / R5
        for (int v = 0; v < NV; v++) begin
            clear_counters();
            wr(A_PR, VECS[v].pr);
            wr(A_MR0, VECS[v].mr);
            wr(A_MCR, (VECS[v].mode == 2'd1) ? 32'h3 :
                      (VECS[v].mode == 2'd2) ? 32'h5 : 32'h0);
            run_edges(int'(VECS[v].k));
            ticks = int'(VECS[v].k / (VECS[v].pr + 1));
            e_pc  = int'(VECS[v].k % (VECS[v].pr + 1));
            e_ir  = 0;
            if (VECS[v].mode == 2'd0) begin
                e_tc = ticks;
            end else if (VECS[v].mode == 2'd1) begin
                e_tc = ticks % int'(VECS[v].mr + 1);
                e_ir = (ticks > int'(VECS[v].mr)) ? 1 : 0;
            end else begin
                if (ticks > int'(VECS[v].mr)) begin
                    e_tc = int'(VECS[v].mr);
                    e_pc = 0;
                    e_ir = 1;
                end else begin
                    e_tc = ticks;
                end
            end
            rd(A_TC, r);
            chk((VECS[v].mode == 2'd0) ? "R2 timer count" :
                (VECS[v].mode == 2'd1) ? "R6 restart count" : "R7 halt count", r, 32'(e_tc));
            rd(A_PC, r);
            chk("R2 prescale residue", r, 32'(e_pc));
            rd(A_IR, r);
            chk("R5 match flag", r, 32'(e_ir));
        end

        // R3: disabled counters do not move
        rd(A_TC, r);
        repeat (10) @(negedge clk);
        rd(A_TC, r2);
        chk("R3 disabled timer stable", r2, r);

        // R7: halt on channel 1 clears enable, no flag without flag bit
        clear_counters();
        wr(A_PR, 32'h0);
        wr(A_MR1, 32'h3);
        wr(A_MCR, 32'h20);
        wr(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        rd(A_CTRL, r);
        chk("R7 enable cleared by halt", r, 32'h0);
        rd(A_TC, r);
        chk("R7 timer at compare value", r, 32'h3);
        rd(A_IR, r);
        chk("R7 no flag without flag bit", r, 32'h0);

        // R5 / R8: flag-only match on channel 2, write-one-to-clear
        clear_counters();
        wr(A_MR2, 32'h2);
        wr(A_MCR, 32'h40);
        run_edges(5);
        rd(A_TC, r);
        chk("R5 flag-only match keeps counting", r, 32'h5);
        rd(A_IR, r);
        chk("R5 channel 2 flag", r, 32'h4);
        chk("R5 irq high", {31'b0, irq}, 32'h1);
        wr(A_IR, 32'h0);
        rd(A_IR, r);
        chk("R8 zero write keeps flag", r, 32'h4);
        wr(A_IR, 32'h4);
        rd(A_IR, r);
        chk("R8 one write clears flag", r, 32'h0);
        chk("R8 irq low when clear", {31'b0, irq}, 32'h0);

        // R4: hold-in-reset overrides enable
        wr(A_MCR, 32'h0);
        wr(A_TC, 32'd50);
        wr(A_CTRL, 32'h3);
        repeat (5) @(negedge clk);
        rd(A_TC, r);
        chk("R4 timer held zero", r, 32'h0);
        rd(A_PC, r);
        chk("R4 prescale held zero", r, 32'h0);
        wr(A_CTRL, 32'h0);

        // R12: bus writes to counters, preloaded prescale counter
        wr(A_TC, 32'hDEAD0000);
        wr(A_PR, 32'd9);
        wr(A_PC, 32'd7);
        rd(A_TC, r);
        chk("R12 timer write", r, 32'hDEAD0000);
        rd(A_PC, r);
        chk("R12 prescale counter write", r, 32'd7);
        run_edges(5);
        rd(A_PC, r);
        chk("R12 prescale resumes from written value", r, 32'd2);
        rd(A_TC, r);
        chk("R12 single step after preload", r, 32'hDEAD0001);

        // R9 / R11: rising capture with flag on channel 0
        wr(A_IR, 32'hFF);
        wr(A_CCR, 32'h05);
        wr(A_TC, 32'h1234);
        cap_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_CR0, r);
        chk("R9 rising capture", r, 32'h1234);
        rd(A_IR, r);
        chk("R11 capture flag channel 0", r, 32'h10);

        // R10: unselected falling edge ignored on channel 0
        wr(A_TC, 32'h55);
        cap_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_CR0, r);
        chk("R10 unselected falling edge ignored", r, 32'h1234);

        // R10 / R11: falling-only, no flag, on channel 1
        wr(A_IR, 32'hFF);
        wr(A_CCR, 32'h10);
        wr(A_TC, 32'h66);
        cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_CR1, r);
        chk("R10 unselected rising edge ignored", r, 32'h0);
        wr(A_TC, 32'h77);
        cap_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_CR1, r);
        chk("R10 falling capture", r, 32'h77);
        rd(A_IR, r);
        chk("R11 no flag without flag bit", r, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule